// File: doc/BRIEF.md
# Accumulator ALU with Operand Pre-Shifter

This block is the accumulator datapath of a 16-bit fixed-point signal processor. Each cycle it can accept one decoded 16-bit instruction word together with a 16-bit operand. The operand has already been fetched, either from data memory or from the second word of a long-immediate form. In that same clock the block updates a 32-bit accumulator, a carry flag and a sticky overflow flag. Before an arithmetic operation combines the operand, the operand is shifted left. The shift count comes from a 4-bit instruction field, from the multiplier's T register, or is a fixed sixteen.

Stores are built by the surrounding pipeline. It reads the accumulator's high and low halves straight from the registered outputs. A configuration input selects saturation on signed overflow instead of two's-complement wrap. A separate input clears the sticky overflow flag.

All results are registered. A change caused by an instruction sampled at a rising edge is visible on the outputs right after that edge.

Top module: `acc_shift_alu`

## Requirements
- R1: A clock edge with `rst` high sets the accumulator to 0 and clears both the carry and the overflow flags.
- R2: Instructions with top nibble 0001 (load), 0010 (add) and 0011 (subtract) sign-extend the operand to 32 bits and shift it left by `instr[11:8]`. The low byte is ignored.
- R3: The upper bytes 0x6A (load), 0x61 (add) and 0x65 (subtract) use the sign-extended operand shifted left by exactly 16.
- R4: The upper bytes 0x63 (add) and 0x67 (subtract) use the sign-extended operand shifted left by `treg_shift`.
- R5: The upper bytes 0x62 (add) and 0x66 (subtract) zero-extend the operand and do not shift it.
- R6: 0x60 adds the sign-extended operand plus the carry. 0x64 subtracts the operand and then also subtracts one when the carry is 0. After any add or subtract, carry is the carry out of bit 31, which for a subtract means "no borrow". Loads, logic operations, negate and absolute value leave the carry unchanged.
- R7: 0x6E (AND), 0x6D (OR) and 0x6C (XOR) combine the accumulator with the zero-extended operand. 0x69 loads the zero-extended operand, so the high word becomes 0.
- R8: 0x68 loads (operand << 16) + 0x8000.
- R9: Instruction words 0xBE00 (absolute value), 0xBE01 (one's complement) and 0xBE02 (negate) operate on the accumulator.
- R10: 0xBE09 shifts left and 0xBE0A shifts right arithmetically, and the bit shifted out goes to carry. 0xBE0C rotates left and 0xBE0D rotates right through carry.
- R11: A signed overflow on add, subtract, negate or absolute value sets `ovf`. `ovf` then stays set until a cycle with `ovf_clear` high and no new overflow. With `sat_en` low, the result wraps.
- R12: With `sat_en` high, an overflowing result is replaced by 0x7FFFFFFF for positive overflow or 0x80000000 for negative overflow.
- R13: When `op_valid` is low, or the opcode is not listed above, the accumulator and the carry do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction and operand are valid this cycle |
| instr | input | 16 | Decoded instruction word |
| operand | input | 16 | Fetched data or immediate word |
| treg_shift | input | 4 | Shift count taken from the T register |
| sat_en | input | 1 | Saturate on signed overflow |
| ovf_clear | input | 1 | Clear the sticky overflow flag |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| carry | output | 1 | Carry flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
All architectural state is on the ports, so a wrong internal value appears at the very next edge. A bad shift count, a wrong extension or a wrong carry input corrupts `acc_hi`/`acc_lo` immediately. A wrong carry also shows up one instruction later, through add-with-carry or a rotate. An overflow that is detected wrongly, or a flag that is not sticky, is visible on `ovf` over the following idle and clear cycles. A faulty saturation direction shows as the wrong extreme value in the same cycle. The bench compares all four outputs against a behavioural model after every edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int unsigned DATA_W = 16;
  localparam int unsigned ACC_W  = 2 * DATA_W;
  localparam int unsigned SH_W   = $clog2(DATA_W) + 1;
  localparam int unsigned INSN_W = 16;

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_LOAD, OP_LOADLO, OP_RND, OP_AND, OP_OR,
    OP_XOR, OP_ABS, OP_CMPL, OP_NEG, OP_SFL, OP_SFR, OP_ROL, OP_ROR
  } alu_op_e;

  typedef struct packed {
    alu_op_e           op;
    logic              use_c;
    logic              zext;
    logic [SH_W-1:0]   shamt;
  } dec_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  input  logic [SH_W-2:0]   treg_shift,
  output dec_t              dec
);
  localparam logic [SH_W-1:0] SH16 = SH_W'(DATA_W);

  always_comb begin
    dec = '{op: OP_NOP, use_c: 1'b0, zext: 1'b0, shamt: '0};
    case (instr[15:12])
      4'h1: begin dec.op = OP_LOAD; dec.shamt = SH_W'(instr[11:8]); end
      4'h2: begin dec.op = OP_ADD;  dec.shamt = SH_W'(instr[11:8]); end
      4'h3: begin dec.op = OP_SUB;  dec.shamt = SH_W'(instr[11:8]); end
      4'h6: begin
        case (instr[11:8])
          4'h0: begin dec.op = OP_ADD; dec.use_c = 1'b1; end
          4'h1: begin dec.op = OP_ADD; dec.shamt = SH16; end
          4'h2: begin dec.op = OP_ADD; dec.zext = 1'b1; end
          4'h3: begin dec.op = OP_ADD; dec.shamt = SH_W'(treg_shift); end
          4'h4: begin dec.op = OP_SUB; dec.use_c = 1'b1; end
          4'h5: begin dec.op = OP_SUB; dec.shamt = SH16; end
          4'h6: begin dec.op = OP_SUB; dec.zext = 1'b1; end
          4'h7: begin dec.op = OP_SUB; dec.shamt = SH_W'(treg_shift); end
          4'h8: dec.op = OP_RND;
          4'h9: dec.op = OP_LOADLO;
          4'hA: begin dec.op = OP_LOAD; dec.shamt = SH16; end
          4'hC: begin dec.op = OP_XOR; dec.zext = 1'b1; end
          4'hD: begin dec.op = OP_OR;  dec.zext = 1'b1; end
          4'hE: begin dec.op = OP_AND; dec.zext = 1'b1; end
          default: dec.op = OP_NOP;
        endcase
      end
      4'hB: begin
        if (instr[11:4] == 8'hE0) begin
          case (instr[3:0])
            4'h0: dec.op = OP_ABS;
            4'h1: dec.op = OP_CMPL;
            4'h2: dec.op = OP_NEG;
            4'h9: dec.op = OP_SFL;
            4'hA: dec.op = OP_SFR;
            4'hC: dec.op = OP_ROL;
            4'hD: dec.op = OP_ROR;
            default: dec.op = OP_NOP;
          endcase
        end
      end
      default: dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/acc_alu_preshift.sv
module acc_alu_preshift
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] opd,
  input  logic              zext,
  input  logic [SH_W-1:0]   shamt,
  output logic [ACC_W-1:0]  shifted
);
  logic [ACC_W-1:0] widened;

  always_comb begin
    widened = zext ? {{DATA_W{1'b0}}, opd} : {{DATA_W{opd[DATA_W-1]}}, opd};
    shifted = widened << shamt;
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] x;
  logic [W:0]   sum;

  always_comb begin
    x    = sub ? ~b : b;
    sum  = {1'b0, a} + {1'b0, x} + {{W{1'b0}}, cin};
    cout = sum[W];
    ovf  = (a[W-1] == x[W-1]) && (sum[W-1] != a[W-1]);
    if (ovf && sat_en) res = a[W-1] ? NEG_MIN : POS_MAX;
    else               res = sum[W-1:0];
  end
endmodule

// File: rtl/acc_shift_alu.sv
module acc_shift_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [15:0]       instr,
  input  logic [15:0]       operand,
  input  logic [3:0]        treg_shift,
  input  logic              sat_en,
  input  logic              ovf_clear,
  output logic [15:0]       acc_hi,
  output logic [15:0]       acc_lo,
  output logic              carry,
  output logic              ovf
);
  localparam logic [ACC_W-1:0] RND_K   = ACC_W'(1) << (DATA_W - 1);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             carry_q, carry_d, ovf_q, ovf_d, ovf_evt;
  dec_t             dec;
  logic [ACC_W-1:0] bsh;
  logic [ACC_W-1:0] ar_a, ar_b, ar_res;
  logic             ar_sub, ar_cin, ar_cout, ar_ovf;

  acc_alu_decode u_dec (.instr(instr), .treg_shift(treg_shift), .dec(dec));

  acc_alu_preshift u_shift (
    .opd(operand), .zext(dec.zext), .shamt(dec.shamt), .shifted(bsh)
  );

  always_comb begin
    ar_a = acc_q; ar_b = bsh; ar_sub = 1'b0; ar_cin = 1'b0;
    case (dec.op)
      OP_ADD: ar_cin = dec.use_c & carry_q;
      OP_SUB: begin ar_sub = 1'b1; ar_cin = dec.use_c ? carry_q : 1'b1; end
      OP_ABS, OP_NEG: begin
        ar_a = '0; ar_b = acc_q; ar_sub = 1'b1; ar_cin = 1'b1;
      end
      default: ;
    endcase
  end

  acc_alu_addsub #(.W(ACC_W)) u_arith (
    .a(ar_a), .b(ar_b), .sub(ar_sub), .cin(ar_cin), .sat_en(sat_en),
    .res(ar_res), .cout(ar_cout), .ovf(ar_ovf)
  );

  always_comb begin
    acc_d = acc_q; carry_d = carry_q; ovf_evt = 1'b0;
    if (op_valid) begin
      case (dec.op)
        OP_ADD, OP_SUB: begin acc_d = ar_res; carry_d = ar_cout; ovf_evt = ar_ovf; end
        OP_NEG:    begin acc_d = ar_res; ovf_evt = ar_ovf; end
        OP_ABS:    if (acc_q[ACC_W-1]) begin acc_d = ar_res; ovf_evt = ar_ovf; end
        OP_LOAD:   acc_d = bsh;
        OP_LOADLO: acc_d = {{DATA_W{1'b0}}, operand};
        OP_RND:    acc_d = {operand, {DATA_W{1'b0}}} + RND_K;
        OP_AND:    acc_d = acc_q & bsh;
        OP_OR:     acc_d = acc_q | bsh;
        OP_XOR:    acc_d = acc_q ^ bsh;
        OP_CMPL:   acc_d = ~acc_q;
        OP_SFL:    begin carry_d = acc_q[ACC_W-1]; acc_d = {acc_q[ACC_W-2:0], 1'b0}; end
        OP_SFR:    begin carry_d = acc_q[0]; acc_d = {acc_q[ACC_W-1], acc_q[ACC_W-1:1]}; end
        OP_ROL:    begin carry_d = acc_q[ACC_W-1]; acc_d = {acc_q[ACC_W-2:0], carry_q}; end
        OP_ROR:    begin carry_d = acc_q[0]; acc_d = {carry_q, acc_q[ACC_W-1:1]}; end
        default: ;
      endcase
    end
    ovf_d = (ovf_q & ~ovf_clear) | ovf_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0; carry_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d; carry_q <= carry_d; ovf_q <= ovf_d;
    end
  end

  assign acc_hi = acc_q[ACC_W-1:DATA_W];
  assign acc_lo = acc_q[DATA_W-1:0];
  assign carry  = carry_q;
  assign ovf    = ovf_q;

  // R1: reset clears every state bit
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !carry_q && !ovf_q));

  // R13: idle cycles leave accumulator and carry untouched
  p_hold_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && $stable(carry_q)));

  // R11: overflow flag is sticky
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clear) |=> ovf_q);

  // R11: clearing without a new instruction drops the flag
  p_ovf_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !op_valid) |=> !ovf_q);

  // R12: saturated overflow lands on an extreme value
  p_sat_extreme_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sat_en && ovf_evt) |=> (acc_q == POS_MAX || acc_q == NEG_MIN));

  // R8: rounding load leaves the half-LSB pattern in the low word
  p_round_low_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec.op == OP_RND) |=> (acc_q[DATA_W-1:0] == RND_K[DATA_W-1:0]));
endmodule

// File: tb/acc_shift_alu_test.sv
module acc_shift_alu_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] instr = '0, operand = '0;
  logic [3:0]  treg_shift = '0;
  logic        sat_en = 1'b0, ovf_clear = 1'b0;
  logic [15:0] acc_hi, acc_lo;
  logic        carry, ovf;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [31:0] m_acc = '0;
  logic        m_c = 1'b0, m_v = 1'b0;

  acc_shift_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr), .operand(operand),
    .treg_shift(treg_shift), .sat_en(sat_en), .ovf_clear(ovf_clear),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .carry(carry), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic compare(input string tag);
    n_checks++;
    if ({acc_hi, acc_lo} !== m_acc || carry !== m_c || ovf !== m_v) begin
      n_fail++;
      $display("FAIL %s: actual acc=%h c=%b v=%b expected acc=%h c=%b v=%b",
               tag, {acc_hi, acc_lo}, carry, ovf, m_acc, m_c, m_v);
    end
  endtask

  // Behavioural reference: signed/unsigned integer arithmetic per instruction.
  task automatic model(input logic v, input logic [15:0] ins, input logic [15:0] od,
                       input logic [3:0] t, input logic sat, input logic clr);
    longint sa, sb, s, u, bv;
    logic [31:0] b32;
    int kind = 0;      // 0 none, 1 add, 2 sub, 3 load, 4 other
    int sh = 0;
    bit zx = 0, withc = 0, newv = 0;
    logic [31:0] r = m_acc;
    logic rc = m_c;
    logic [3:0] hi = ins[15:12], md = ins[11:8];
    if (v) begin
      if (hi == 4'h1) begin kind = 3; sh = md; end
      else if (hi == 4'h2) begin kind = 1; sh = md; end
      else if (hi == 4'h3) begin kind = 2; sh = md; end
      else if (hi == 4'h6) begin
        case (md)
          4'h0: begin kind = 1; withc = 1; end
          4'h1: begin kind = 1; sh = 16; end
          4'h2: begin kind = 1; zx = 1; end
          4'h3: begin kind = 1; sh = t; end
          4'h4: begin kind = 2; withc = 1; end
          4'h5: begin kind = 2; sh = 16; end
          4'h6: begin kind = 2; zx = 1; end
          4'h7: begin kind = 2; sh = t; end
          4'hA: begin kind = 3; sh = 16; end
          4'h8: begin kind = 4; r = {od, 16'h0} + 32'h8000; end
          4'h9: begin kind = 4; r = {16'h0, od}; end
          4'hC: begin kind = 4; r = m_acc ^ {16'h0, od}; end
          4'hD: begin kind = 4; r = m_acc | {16'h0, od}; end
          4'hE: begin kind = 4; r = m_acc & {16'h0, od}; end
          default: ;
        endcase
      end
      bv = zx ? longint'({48'h0, od}) : longint'($signed(od));
      bv = bv * (64'sd1 <<< sh);
      b32 = bv[31:0];
      sa = longint'($signed(m_acc)); sb = longint'($signed(b32));
      if (kind == 1) begin
        s = sa + sb + ((withc && m_c) ? 1 : 0);
        u = longint'({32'h0, m_acc}) + longint'({32'h0, b32}) + ((withc && m_c) ? 1 : 0);
        rc = (u >= 64'sh1_0000_0000);
        newv = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
        r = s[31:0];
        if (newv && sat) r = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      end else if (kind == 2) begin
        s = sa - sb - ((withc && !m_c) ? 1 : 0);
        u = longint'({32'h0, m_acc}) - longint'({32'h0, b32}) - ((withc && !m_c) ? 1 : 0);
        rc = (u >= 0);
        newv = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
        r = s[31:0];
        if (newv && sat) r = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      end else if (kind == 3) begin
        r = b32;
      end else if (ins[15:4] == 12'hBE0) begin
        case (ins[3:0])
          4'h0, 4'h2: if (ins[3:0] == 4'h2 || sa < 0) begin
            s = -sa;
            newv = (s > 64'sh7FFF_FFFF);
            r = (newv && sat) ? 32'h7FFF_FFFF : s[31:0];
          end
          4'h1: r = ~m_acc;
          4'h9: begin rc = m_acc[31]; r = m_acc << 1; end
          4'hA: begin rc = m_acc[0]; r = $signed(m_acc) >>> 1; end
          4'hC: begin rc = m_acc[31]; r = {m_acc[30:0], m_c}; end
          4'hD: begin rc = m_acc[0]; r = {m_c, m_acc[31:1]}; end
          default: ;
        endcase
      end
    end
    m_acc = r; m_c = rc;
    m_v = (m_v && !clr) || newv;
  endtask

  task automatic step(input string tag, input logic v, input logic [15:0] ins,
                      input logic [15:0] od, input logic [3:0] t = 4'd0,
                      input logic sat = 1'b0, input logic clr = 1'b0);
    op_valid = v; instr = ins; operand = od; treg_shift = t; sat_en = sat; ovf_clear = clr;
    model(v, ins, od, t, sat, clr);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; op_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    m_acc = '0; m_c = 1'b0; m_v = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset("R1 reset state");
    // R2: 4-bit field shift, sign-extended
    step("R2 load<<4",   1, 16'h1433, 16'h0123);
    step("R2 add<<0",    1, 16'h2000, 16'hFFFF);
    step("R2 sub<<15",   1, 16'h3F00, 16'h0002);
    step("R2 load<<3 neg", 1, 16'h1355, 16'h8000);
    // R3: shift by 16
    step("R3 load<<16",  1, 16'h6A10, 16'h1234);
    step("R3 add<<16",   1, 16'h6110, 16'h0001);
    step("R3 sub<<16",   1, 16'h6510, 16'h0003);
    // R4: T-register shift
    step("R4 add<<T",    1, 16'h6305, 16'h0001, 4'd7);
    step("R4 sub<<T",    1, 16'h6705, 16'hFFFF, 4'd15);
    // R5: zero-extended
    step("R5 add zext",  1, 16'h6200, 16'hFFFF);
    step("R5 sub zext",  1, 16'h6600, 16'h8000);
    // R6: carry chain
    step("R6 load -1",   1, 16'h1000, 16'hFFFF);
    step("R6 add carry out", 1, 16'h2000, 16'h0001);
    step("R6 add with carry", 1, 16'h6000, 16'h0005);
    step("R6 sub with borrow", 1, 16'h6400, 16'h0002);
    step("R6 sub no borrow", 1, 16'h6400, 16'h0001);
    // R7: logic and low load
    step("R7 load",      1, 16'h1000, 16'hF0F0);
    step("R7 and",       1, 16'h6E00, 16'h0FF0);
    step("R7 or",        1, 16'h6D00, 16'hFF00);
    step("R7 xor",       1, 16'h6C00, 16'h0FFF);
    step("R7 prep high", 1, 16'h6A00, 16'h8001);
    step("R7 load low",  1, 16'h6900, 16'hABCD);
    // R8: rounding load
    step("R8 round",     1, 16'h6800, 16'h1234);
    step("R8 round neg", 1, 16'h6800, 16'h8000);
    // R9: unary
    step("R9 abs neg",   1, 16'hBE00, 16'h0000);
    step("R9 cmpl",      1, 16'hBE01, 16'h0000);
    step("R9 neg",       1, 16'hBE02, 16'h0000);
    step("R9 abs pos",   1, 16'hBE00, 16'h0000);
    // R10: shifts and rotates
    step("R10 load",     1, 16'h1000, 16'h8001);
    step("R10 sfl",      1, 16'hBE09, 16'h0);
    step("R10 sfr",      1, 16'hBE0A, 16'h0);
    step("R10 rol",      1, 16'hBE0C, 16'h0);
    step("R10 ror",      1, 16'hBE0D, 16'h0);
    step("R10 ror again", 1, 16'hBE0D, 16'h0);
    // R11: wrap and sticky flag
    step("R11 load max", 1, 16'h6A00, 16'h7FFF);
    step("R11 add wraps", 1, 16'h6100, 16'h7FFF);
    step("R11 sticky",   1, 16'h1000, 16'h0001);
    step("R11 clear",    0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1);
    step("R11 load min", 1, 16'h6A00, 16'h8000);
    step("R11 neg wraps", 1, 16'hBE02, 16'h0);
    step("R11 clear 2",  0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1);
    // R12: saturation
    step("R12 load max", 1, 16'h6A00, 16'h7FFF, 4'd0, 1'b1);
    step("R12 add sat+", 1, 16'h6100, 16'h7FFF, 4'd0, 1'b1);
    step("R12 load min", 1, 16'h6A00, 16'h8000, 4'd0, 1'b1);
    step("R12 sub sat-", 1, 16'h6500, 16'h0001, 4'd0, 1'b1);
    step("R12 neg sat",  1, 16'hBE02, 16'h0, 4'd0, 1'b1);
    step("R12 load min2", 1, 16'h6A00, 16'h8000, 4'd0, 1'b1);
    step("R12 abs sat",  1, 16'hBE00, 16'h0, 4'd0, 1'b1);
    // R13: ignored cycles
    step("R13 invalid",  0, 16'h2F00, 16'h1234);
    step("R13 undefined 6B", 1, 16'h6B00, 16'h1234);
    step("R13 undefined BE03", 1, 16'hBE03, 16'h1234);
    step("R13 undefined B0", 1, 16'hB000, 16'h1234);
    do_reset("R1 mid-run reset");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule